// File: doc/BRIEF.md
# Indirect-Access Video Memory Port

This block is the host side of a video controller that owns a private RAM. The host bus sees just two locations. One is a select/status port: writing it chooses an internal register index, and its read value is a status byte that carries a ready flag. The other is the data port, which reads or writes whichever internal register is currently selected. Two of the internal registers hold the high and low bytes of a memory pointer. A third register is a window onto video RAM at that pointer. Every strobed access to that window moves the pointer forward by one.

The display side of the controller is not part of this block. It appears only as a fetch port: the display pipeline asks for a byte, and the byte comes back one cycle later. Fetches always win the RAM cycle. A host access to RAM therefore waits until no fetch is being requested. Nothing signals completion to the host. It must poll the ready flag, and any strobe it issues while the block is busy is silently thrown away.

The host bus is a one-cycle strobe (`host_stb`) qualified by `host_we` and `host_sel`. Read data is presented without delay for the currently addressed location. A strobe is what marks a read as an access: looking at `host_rdata` without a strobe has no side effects.

Top module: `vmp_host_port`

## Requirements
- R1: After reset the status byte reads 0x80 (ready), the pointer is 0, the selected index is 0 and `fetch_valid` is low.
- R2: A strobed write with `host_sel`=0 selects internal register index `host_wdata[4:0]`. A strobed write with `host_sel`=1 to an ordinary index stores the byte, and `host_rdata` with `host_sel`=1 shows it back. Register 25 keeps all eight bits, so a read-modify-write of one field leaves the other field unchanged.
- R3: Index 18 is the pointer high byte and index 19 the pointer low byte. Both can be written and read back through the data port.
- R4: Index 31 is the RAM window. A strobed write stores the byte at the pointer. A strobed read loads the byte at the pointer into the read-back value, which `host_rdata` shows on the data port once ready returns.
- R5: Each accepted strobe on index 31, whether read or write, advances the pointer by exactly one. Two read strobes therefore advance it by two.
- R6: With `host_sel`=0, `host_rdata` bit 7 is the ready flag and bits 6..0 read 0. With no fetch traffic, ready is low for exactly BUSY_CYC cycles after an accepted index-31 access.
- R7: While ready is low, every strobe is ignored. RAM, the pointer, the registers and the selected index are all left unchanged.
- R8: The pointer wraps from 2**ADDR_W-1 to 0.
- R9: While `fetch_req` is held high, a pending host RAM access does not take place and ready stays low. The access completes after `fetch_req` drops.
- R10: A fetch request in one cycle yields `fetch_valid`=1 and `fetch_data` equal to the RAM byte at `fetch_addr` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_stb | input | 1 | One-cycle access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 1 | 0 = select/status port, 1 = data port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Status byte or contents of the selected register |
| fetch_req | input | 1 | Display fetch request |
| fetch_addr | input | ADDR_W | Display fetch address |
| fetch_valid | output | 1 | Fetch byte valid |
| fetch_data | output | 8 | Fetched byte |

## Verification
The bench builds the block with ADDR_W=10 and BUSY_CYC=4. The small address space lets one sequential fill of all 1024 bytes run the pointer across its wrap point and seed a full memory model, which the randomized read and write traffic is then checked against. A busy window of four cycles keeps the exact ready-low count quick to measure. It also leaves room to land a second strobe inside that window, and to hold fetches across it so the host access is starved.

// File: rtl/vmp_pkg.sv
package vmp_pkg;
    localparam int IDX_W          = 5;
    localparam int NREG           = 1 << IDX_W;
    localparam int IDX_PTR_HI     = 18;
    localparam int IDX_PTR_LO     = 19;
    localparam int IDX_DATA       = 31;
    localparam int READY_BIT      = 7;

    typedef enum logic [1:0] {
        RAM_IDLE  = 2'd0,
        RAM_FETCH = 2'd1,
        RAM_HOST  = 2'd2
    } ram_owner_e;
endpackage

// File: rtl/vmp_spram.sv
module vmp_spram #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem_q[addr] <= wdata;
            rdata_q <= mem_q[addr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/vmp_arbiter.sv
module vmp_arbiter
    import vmp_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              host_pend,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output ram_owner_e        owner,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata
);
    always_comb begin
        owner     = RAM_IDLE;
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = fetch_addr;
        ram_wdata = host_wdata;
        if (fetch_req) begin
            owner  = RAM_FETCH;
            ram_en = 1'b1;
        end else if (host_pend) begin
            owner    = RAM_HOST;
            ram_en   = 1'b1;
            ram_we   = host_we;
            ram_addr = host_addr;
        end
    end
endmodule

// File: rtl/vmp_host_port.sv
module vmp_host_port
    import vmp_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int BUSY_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_stb,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_valid,
    output logic [7:0]        fetch_data
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);
    localparam logic [CNT_W-1:0] BUSY_LOAD = CNT_W'(BUSY_CYC);

    typedef struct packed {
        logic [IDX_W-1:0]         sel_idx;
        logic [ADDR_W-1:0]        ptr;
        logic [NREG-1:0][7:0]     regs;
        logic [7:0]               latch;
        logic [CNT_W-1:0]         busy_cnt;
        logic                     pend;
        logic                     op_we;
        logic [ADDR_W-1:0]        op_addr;
        logic [7:0]               op_wdata;
        logic                     rd_ret;
        logic                     fetch_valid;
    } state_t;

    state_t s_q, s_d;

    ram_owner_e        owner;
    logic              ram_en, ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [7:0]        ram_wdata, ram_rdata;
    logic              ready;
    logic              acc_data;
    logic [15:0]       ptr16;
    logic [15:0]       ptr_new;

    vmp_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .fetch_req  (fetch_req),
        .fetch_addr (fetch_addr),
        .host_pend  (s_q.pend),
        .host_we    (s_q.op_we),
        .host_addr  (s_q.op_addr),
        .host_wdata (s_q.op_wdata),
        .owner      (owner),
        .ram_en     (ram_en),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata)
    );

    vmp_spram #(.ADDR_W(ADDR_W), .DATA_W(8)) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    assign ready    = (s_q.busy_cnt == '0) && !s_q.pend && !s_q.rd_ret;
    assign ptr16    = 16'(s_q.ptr);
    assign acc_data = host_stb && ready && host_sel && (s_q.sel_idx == IDX_DATA[IDX_W-1:0]);

    always_comb begin
        s_d         = s_q;
        ptr_new     = ptr16;
        s_d.rd_ret  = 1'b0;
        s_d.fetch_valid = fetch_req;

        if (s_q.busy_cnt != '0) s_d.busy_cnt = s_q.busy_cnt - 1'b1;
        if (s_q.rd_ret)         s_d.latch    = ram_rdata;
        if (owner == RAM_HOST) begin
            s_d.pend   = 1'b0;
            s_d.rd_ret = !s_q.op_we;
        end

        if (host_stb && ready) begin
            if (!host_sel) begin
                if (host_we) s_d.sel_idx = host_wdata[IDX_W-1:0];
            end else if (s_q.sel_idx == IDX_DATA[IDX_W-1:0]) begin
                s_d.pend     = 1'b1;
                s_d.op_we    = host_we;
                s_d.op_addr  = s_q.ptr;
                s_d.op_wdata = host_wdata;
                s_d.ptr      = s_q.ptr + 1'b1;
                s_d.busy_cnt = BUSY_LOAD;
            end else if (host_we) begin
                if (s_q.sel_idx == IDX_PTR_HI[IDX_W-1:0]) begin
                    ptr_new = {host_wdata, ptr16[7:0]};
                    s_d.ptr = ptr_new[ADDR_W-1:0];
                end else if (s_q.sel_idx == IDX_PTR_LO[IDX_W-1:0]) begin
                    ptr_new = {ptr16[15:8], host_wdata};
                    s_d.ptr = ptr_new[ADDR_W-1:0];
                end else begin
                    s_d.regs[s_q.sel_idx] = host_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        if (!host_sel) begin
            host_rdata = '0;
            host_rdata[READY_BIT] = ready;
        end else if (s_q.sel_idx == IDX_DATA[IDX_W-1:0]) begin
            host_rdata = s_q.latch;
        end else if (s_q.sel_idx == IDX_PTR_HI[IDX_W-1:0]) begin
            host_rdata = ptr16[15:8];
        end else if (s_q.sel_idx == IDX_PTR_LO[IDX_W-1:0]) begin
            host_rdata = ptr16[7:0];
        end else begin
            host_rdata = s_q.regs[s_q.sel_idx];
        end
    end

    assign fetch_valid = s_q.fetch_valid;
    assign fetch_data  = ram_rdata;

    // R6: an accepted RAM-window access drops ready on the next cycle
    a_r6_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        acc_data |=> !ready);

    // R5: accepted RAM-window access steps the pointer by one
    a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        acc_data |=> (s_q.ptr == $past(s_q.ptr) + 1'b1));

    // R7: strobes while busy leave pointer and selection untouched
    a_r7_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (host_stb && !ready) |=> ($stable(s_q.ptr) && $stable(s_q.sel_idx)));

    // R9: a pending host access survives a cycle with a fetch request
    a_r9_fetch_first: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pend && fetch_req) |=> s_q.pend);

    // R10: a fetch request is answered in the next cycle
    a_r10_fetch_valid: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> fetch_valid);
endmodule

// File: tb/sim_vmp_host_port.sv
module sim_vmp_host_port;
    localparam int AW   = 10;
    localparam int BUSY = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_stb = 1'b0, host_we = 1'b0, host_sel = 1'b0;
    logic [7:0]    host_wdata = '0;
    logic [7:0]    host_rdata;
    logic          fetch_req = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic          fetch_valid;
    logic [7:0]    fetch_data;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    logic [7:0]    mem_m [DEPTH];
    logic [AW-1:0] ptr_m = '0;

    always #10 clk = ~clk;

    vmp_host_port #(.ADDR_W(AW), .BUSY_CYC(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .host_stb(host_stb), .host_we(host_we),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_valid(fetch_valid), .fetch_data(fetch_data)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] status_exp(input logic rdy);
        return {rdy, 7'b0};
    endfunction

    task automatic strobe(input logic sel, input logic we, input logic [7:0] d);
        @(negedge clk);
        host_sel = sel; host_we = we; host_wdata = d; host_stb = 1'b1;
        @(negedge clk);
        host_stb = 1'b0; host_we = 1'b0;
    endtask

    task automatic wait_ready();
        host_sel = 1'b0;
        for (int i = 0; i < 200; i++) begin
            #1;
            if (host_rdata[7]) return;
            @(negedge clk);
        end
        check("R9 ready timeout", 0, 1);
    endtask

    task automatic peek(output logic [7:0] v);
        host_sel = 1'b1; #1; v = host_rdata;
    endtask

    task automatic select(input int idx);
        strobe(1'b0, 1'b1, 8'(idx));
    endtask

    task automatic set_ptr(input logic [AW-1:0] a);
        logic [15:0] a16;
        a16 = 16'(a);
        select(18); strobe(1'b1, 1'b1, a16[15:8]);
        select(19); strobe(1'b1, 1'b1, a16[7:0]);
        select(31);
        ptr_m = a;
    endtask

    task automatic get_ptr(output logic [AW-1:0] a);
        logic [7:0] hi, lo;
        select(18); peek(hi);
        select(19); peek(lo);
        select(31);
        a = AW'({hi, lo});
    endtask

    task automatic wr_data(input logic [7:0] d);
        strobe(1'b1, 1'b1, d);
        mem_m[ptr_m] = d; ptr_m = ptr_m + 1'b1;
        wait_ready();
    endtask

    task automatic rd_data(output logic [7:0] d);
        strobe(1'b1, 1'b0, 8'h00);
        ptr_m = ptr_m + 1'b1;
        wait_ready();
        peek(d);
    endtask

    initial begin
        logic [7:0]    v, v2;
        logic [AW-1:0] p;
        void'($urandom(32'd1234));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        host_sel = 1'b0; #1;
        check("R1 status", host_rdata, 8'h80);
        check("R1 fetch_valid", fetch_valid, 0);
        host_sel = 1'b1; #1;
        check("R1 index 0 contents", host_rdata, 0);
        get_ptr(p);
        check("R1 pointer", p, 0);

        // R2 general registers and read-modify-write of register 25
        select(5); strobe(1'b1, 1'b1, 8'h3C); peek(v);
        check("R2 reg5 readback", v, 8'h3C);
        select(25); strobe(1'b1, 1'b1, 8'h07); peek(v);
        strobe(1'b1, 1'b1, v | 8'h10); peek(v2);
        check("R2 reg25 rmw keeps fine-scroll field", v2, 8'h17);
        select(5); peek(v);
        check("R2 reg5 untouched", v, 8'h3C);

        // R3 pointer registers
        set_ptr(10'h2A5);
        get_ptr(p);
        check("R3 pointer hi/lo", p, 10'h2A5);

        // R6 ready window length
        strobe(1'b1, 1'b1, 8'h5A);
        mem_m[ptr_m] = 8'h5A; ptr_m++;
        host_sel = 1'b0;
        for (int i = 0; i < BUSY; i++) begin
            #1; check("R6 ready low", host_rdata, status_exp(1'b0));
            @(negedge clk);
        end
        #1; check("R6 ready back", host_rdata, status_exp(1'b1));

        // R4 RAM write then read back
        set_ptr(10'h2A5);
        rd_data(v);
        check("R4 read back", v, 8'h5A);
        get_ptr(p);
        check("R5 pointer after one read", p, 10'h2A6);

        // R5 double read advances twice
        set_ptr(10'h100);
        wr_data(8'h11); wr_data(8'h22); wr_data(8'h33);
        set_ptr(10'h100);
        rd_data(v); rd_data(v2);
        check("R5 first read", v, 8'h11);
        check("R5 second read", v2, 8'h22);
        get_ptr(p);
        check("R5 double read pointer", p, 10'h102);

        // R7 strobes while busy are ignored
        set_ptr(10'h200);
        wr_data(8'hEE); wr_data(8'hEE);
        set_ptr(10'h200);
        @(negedge clk);
        host_sel = 1'b1; host_we = 1'b1; host_wdata = 8'hA1; host_stb = 1'b1;
        @(negedge clk);
        host_wdata = 8'hB2;
        @(negedge clk);
        host_sel = 1'b0; host_wdata = 8'd5;
        @(negedge clk);
        host_stb = 1'b0; host_we = 1'b0;
        mem_m[10'h200] = 8'hA1; ptr_m = 10'h201;
        wait_ready();
        host_sel = 1'b1; #1;
        check("R7 selection kept", host_rdata != 8'h3C, 1);
        get_ptr(p);
        check("R7 pointer stepped once", p, 10'h201);
        rd_data(v);
        check("R7 next byte untouched", v, 8'hEE);
        set_ptr(10'h200); rd_data(v);
        check("R7 first write landed", v, 8'hA1);

        // R8 fill all memory from 0; pointer wraps
        set_ptr('0);
        for (int i = 0; i < DEPTH; i++) wr_data(8'($urandom));
        get_ptr(p);
        check("R8 wrap to zero", p, 0);
        set_ptr(AW'(DEPTH - 1));
        wr_data(8'h99);
        get_ptr(p);
        check("R8 wrap from top", p, 0);

        // R9 / R10 fetch priority and fetch data
        set_ptr(10'h050);
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = 10'h123;
        host_sel = 1'b1; host_we = 1'b1; host_wdata = 8'h77; host_stb = 1'b1;
        @(negedge clk);
        host_stb = 1'b0; host_we = 1'b0;
        check("R10 fetch valid", fetch_valid, 1);
        check("R10 fetch data", fetch_data, mem_m[10'h123]);
        for (int i = 0; i < BUSY + 3; i++) @(negedge clk);
        host_sel = 1'b0; #1;
        check("R9 ready held by fetches", host_rdata, status_exp(1'b0));
        fetch_addr = 10'h3FF;
        @(negedge clk);
        check("R10 fetch top byte", fetch_data, 8'h99);
        fetch_req = 1'b0;
        mem_m[10'h050] = 8'h77; ptr_m = 10'h051;
        wait_ready();
        set_ptr(10'h050); rd_data(v);
        check("R9 host write completes", v, 8'h77);

        // randomized traffic against the model (R4 R5 R10)
        for (int n = 0; n < 150; n++) begin
            int op;
            op = int'($urandom % 4);
            if (op == 0) begin
                set_ptr(AW'($urandom));
            end else if (op == 1) begin
                wr_data(8'($urandom));
            end else if (op == 2) begin
                logic [AW-1:0] a;
                a = ptr_m;
                rd_data(v);
                check("R4 random read", v, mem_m[a]);
            end else begin
                @(negedge clk);
                fetch_req = 1'b1; fetch_addr = AW'($urandom);
                @(negedge clk);
                check("R10 random fetch", fetch_data, mem_m[fetch_addr]);
                fetch_req = 1'b0;
            end
        end
        get_ptr(p);
        check("R5 pointer tracks model", p, ptr_m);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule